// File: doc/BRIEF.md
# UART Transmit Descriptor Ring Engine

This block feeds a UART transmitter from a ring of transmit descriptors kept in a word-wide dual-port RAM. Each descriptor spans four consecutive 16-bit words: a status/control word, a byte count and a 32-bit byte pointer. The engine reads the descriptor and streams the buffer's bytes out on a valid/ready byte stream. When the buffer is done it writes the status word back and can flag a transmit event that drives an interrupt. Software hands a descriptor to the engine by setting its Ready bit. The ring length is set only by which descriptor carries Wrap.

The byte stream obeys the usual back-pressure rules. Once `tx_valid` is high, it stays high and `tx_data` stays unchanged until a cycle in which `tx_ready` is high. That cycle transfers the byte. The serializer may hold `tx_ready` low for as long as it likes, and the engine then waits. The RAM port returns read data in the cycle after `mem_rd_en`. The table base `tbase` must stay constant while the engine is enabled or still busy.

Top module: `uart_txd_ring`

## Requirements
- R1: A descriptor at word address A holds status at A, byte count at A+1, pointer high half at A+2 and pointer low half at A+3. The first descriptor sits at `tbase`, and descriptors are 4 words apart. The engine never reads and writes the RAM in the same cycle.
- R2: Status bit positions are Ready 15, Wrap 13, Interrupt 12, Continuous 9 and Preamble 8. All other bits are reserved and are written back unchanged.
- R3: A descriptor whose Ready bit is 0 produces no bytes and is not written. The engine moves past it, honouring its Wrap bit.
- R4: After the last character of a descriptor is accepted, the status word is written once to the descriptor's own address. Ready is 0 in that write unless Continuous is set.
- R5: After a descriptor with Wrap set, the next descriptor fetched is the one at `tbase`. Otherwise it is the next descriptor, 4 words on.
- R6: Buffer bytes go out in ascending byte address, one per accepted handshake. An even byte address takes bits 15:8 of word (address>>1) and an odd one takes bits 7:0. `tx_data` is held stable while `tx_valid` is high and `tx_ready` is low.
- R7: With Preamble set, one 0xFF character is sent before the data. With Preamble set and a count of 0, that 0xFF is the only character sent.
- R8: A count of 0 without Preamble closes the descriptor with no character sent.
- R9: With Continuous set, Ready stays 1 in the write-back, so the buffer is sent again each time the ring returns to that descriptor.
- R10: `tx_evt` goes to 1 the cycle after a descriptor with Interrupt set is closed. A pulse on `tx_evt_clr` clears it (write-one-to-clear), and a set in the same cycle wins.
- R11: `irq` is high exactly when `tx_evt` and `tx_evt_mask` are both 1.
- R12: Raising `enable` starts fetching at `tbase`. Lowering `enable` lets a character already on the stream finish. After that no new character starts, the engine goes idle with its pointer back at `tbase`, and the RAM is not accessed.
- R13: During and straight after reset, `tx_valid`, `mem_rd_en`, `mem_wr_en`, `tx_evt` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the ring engine |
| tbase | input | AW | Word address of the first descriptor |
| mem_rd_en | output | 1 | RAM read strobe |
| mem_wr_en | output | 1 | RAM write strobe (status write-back) |
| mem_addr | output | AW | RAM word address |
| mem_wdata | output | 16 | RAM write data |
| mem_rdata | input | 16 | RAM read data, valid the cycle after `mem_rd_en` |
| tx_valid | output | 1 | Character available to the serializer |
| tx_ready | input | 1 | Serializer accepts the character |
| tx_data | output | 8 | Character |
| tx_evt_clr | input | 1 | Write-one-to-clear pulse for the transmit event |
| tx_evt_mask | input | 1 | Interrupt enable for the transmit event |
| tx_evt | output | 1 | Transmit event bit |
| irq | output | 1 | Interrupt request |

## Verification
Timing from `enable` rising to results:
- The status read is issued 1 cycle after `enable` rises.
- The four descriptor words arrive over the next 4 cycles.
- A preamble can be on the stream 5 cycles after the status read.
- Each data byte needs 2 cycles of fetch before it is offered.
- The status write-back happens in the cycle after the last accepted handshake.
- `tx_evt` follows one cycle after that, and `irq` follows `tx_evt` in the same cycle.

Because the serializer's back-pressure changes these counts, the scoreboard does not count cycles. It compares each byte at the falling edge that comes before the rising edge where the transfer happens. Status words are polled in the bench RAM model until the write-back appears, with a bounded wait. The interrupt and event checks are sampled at the falling edge after the clock edge that updates them.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int unsigned WORD_W      = 16;
  localparam int unsigned DESC_STRIDE = 4;
  localparam int unsigned SW_RDY      = 15;
  localparam int unsigned SW_WRAP     = 13;
  localparam int unsigned SW_INT      = 12;
  localparam int unsigned SW_CONT     = 9;
  localparam int unsigned SW_PRE      = 8;
  localparam logic [7:0]  IDLE_CHAR   = 8'hFF;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ST_RD,
    S_LEN_RD,
    S_PH_RD,
    S_PL_RD,
    S_PL_LAT,
    S_PRE,
    S_BRD,
    S_BLAT,
    S_BSEND,
    S_CLOSE
  } txr_state_e;
endpackage

// File: rtl/txr_byte_pick.sv
module txr_byte_pick import txr_pkg::*; (
  input  logic [WORD_W-1:0] word_i,
  input  logic              odd_i,
  output logic [7:0]        byte_o
);
  // even byte address -> upper half, odd -> lower half
  assign byte_o = odd_i ? word_i[7:0] : word_i[15:8];
endmodule

// File: rtl/txr_event.sv
module txr_event (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic evt_o,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     evt_o <= 1'b0;
    else if (set_i) evt_o <= 1'b1;
    else if (clr_i) evt_o <= 1'b0;
  end

  assign irq_o = evt_o & mask_i;

  // R10
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> evt_o);

  // R10
  evt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !set_i |=> !evt_o);
endmodule

// File: rtl/txr_ctrl.sv
module txr_ctrl import txr_pkg::*; #(
  parameter int unsigned AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic [AW-1:0]     tbase_i,
  output logic              mem_rd_en_o,
  output logic              mem_wr_en_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic [7:0]        pick_byte_i,
  output logic              byte_odd_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [7:0]        tx_data_o,
  output logic              close_evt_o
);
  localparam int unsigned  BAW    = AW + 1;
  localparam logic [AW-1:0] STRIDE = AW'(DESC_STRIDE);

  txr_state_e        st_q;
  logic [AW-1:0]     cur_q;
  logic [WORD_W-1:0] stat_q, len_q, phi_q, cnt_q;
  logic [BAW-1:0]    baddr_q;
  logic [7:0]        byte_q;

  logic [2*WORD_W-1:0] ptr_full;
  logic                unused_ptr_hi;
  logic [AW-1:0]       next_desc, skip_desc;
  logic                fire;

  assign ptr_full      = {phi_q, mem_rdata_i};
  assign unused_ptr_hi = ^ptr_full[2*WORD_W-1:BAW];
  assign next_desc     = stat_q[SW_WRAP]      ? tbase_i : cur_q + STRIDE;
  assign skip_desc     = mem_rdata_i[SW_WRAP] ? tbase_i : cur_q + STRIDE;
  assign fire          = tx_valid_o && tx_ready_i;

  always_comb begin
    mem_rd_en_o = 1'b0;
    mem_addr_o  = cur_q;
    unique case (st_q)
      S_ST_RD:  mem_rd_en_o = enable_i;
      S_LEN_RD: begin
        mem_rd_en_o = enable_i && mem_rdata_i[SW_RDY];
        mem_addr_o  = cur_q + AW'(1);
      end
      S_PH_RD: begin
        mem_rd_en_o = enable_i;
        mem_addr_o  = cur_q + AW'(2);
      end
      S_PL_RD: begin
        mem_rd_en_o = enable_i;
        mem_addr_o  = cur_q + AW'(3);
      end
      S_BRD: begin
        mem_rd_en_o = enable_i;
        mem_addr_o  = baddr_q[BAW-1:1];
      end
      default: ;
    endcase
  end

  always_comb begin
    mem_wdata_o         = stat_q;
    mem_wdata_o[SW_RDY] = stat_q[SW_CONT];
  end

  assign mem_wr_en_o = (st_q == S_CLOSE);
  assign close_evt_o = (st_q == S_CLOSE) && stat_q[SW_INT];
  assign tx_valid_o  = (st_q == S_PRE) || (st_q == S_BSEND);
  assign tx_data_o   = (st_q == S_PRE) ? IDLE_CHAR : byte_q;
  assign byte_odd_o  = baddr_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      cur_q   <= '0;
      stat_q  <= '0;
      len_q   <= '0;
      phi_q   <= '0;
      cnt_q   <= '0;
      baddr_q <= '0;
      byte_q  <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          cur_q <= tbase_i;
          if (enable_i) st_q <= S_ST_RD;
        end
        S_ST_RD: st_q <= enable_i ? S_LEN_RD : S_IDLE;
        S_LEN_RD: begin
          stat_q <= mem_rdata_i;
          if (!enable_i) st_q <= S_IDLE;
          else if (!mem_rdata_i[SW_RDY]) begin
            cur_q <= skip_desc;
            st_q  <= S_ST_RD;
          end else st_q <= S_PH_RD;
        end
        S_PH_RD: begin
          len_q <= mem_rdata_i;
          st_q  <= enable_i ? S_PL_RD : S_IDLE;
        end
        S_PL_RD: begin
          phi_q <= mem_rdata_i;
          st_q  <= enable_i ? S_PL_LAT : S_IDLE;
        end
        S_PL_LAT: begin
          baddr_q <= ptr_full[BAW-1:0];
          cnt_q   <= len_q;
          if (!enable_i)                st_q <= S_IDLE;
          else if (stat_q[SW_PRE])      st_q <= S_PRE;
          else if (len_q == '0)         st_q <= S_CLOSE;
          else                          st_q <= S_BRD;
        end
        S_PRE: begin
          if (fire) begin
            if (!enable_i)         st_q <= S_IDLE;
            else if (cnt_q == '0)  st_q <= S_CLOSE;
            else                   st_q <= S_BRD;
          end
        end
        S_BRD: st_q <= enable_i ? S_BLAT : S_IDLE;
        S_BLAT: begin
          byte_q <= pick_byte_i;
          st_q   <= enable_i ? S_BSEND : S_IDLE;
        end
        S_BSEND: begin
          if (fire) begin
            baddr_q <= baddr_q + BAW'(1);
            cnt_q   <= cnt_q - WORD_W'(1);
            if (!enable_i)                  st_q <= S_IDLE;
            else if (cnt_q == WORD_W'(1))   st_q <= S_CLOSE;
            else                            st_q <= S_BRD;
          end
        end
        S_CLOSE: begin
          cur_q <= next_desc;
          st_q  <= enable_i ? S_ST_RD : S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  // R1
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en_o && mem_wr_en_o));

  // R1
  wb_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en_o |-> mem_addr_o[1:0] == tbase_i[1:0]);

  // R4
  wb_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en_o && !mem_wdata_o[SW_CONT] |-> !mem_wdata_o[SW_RDY]);

  // R12
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i && !tx_valid_o |=> !tx_valid_o);
endmodule

// File: rtl/uart_txd_ring.sv
module uart_txd_ring import txr_pkg::*; #(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [AW-1:0] tbase,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  input  logic          tx_evt_clr,
  input  logic          tx_evt_mask,
  output logic          tx_evt,
  output logic          irq
);
  logic [7:0] pick_byte;
  logic       byte_odd;
  logic       close_evt;

  txr_ctrl #(.AW(AW)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (enable),
    .tbase_i     (tbase),
    .mem_rd_en_o (mem_rd_en),
    .mem_wr_en_o (mem_wr_en),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .pick_byte_i (pick_byte),
    .byte_odd_o  (byte_odd),
    .tx_valid_o  (tx_valid),
    .tx_ready_i  (tx_ready),
    .tx_data_o   (tx_data),
    .close_evt_o (close_evt)
  );

  txr_byte_pick pick_i (
    .word_i (mem_rdata),
    .odd_i  (byte_odd),
    .byte_o (pick_byte)
  );

  txr_event evt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (close_evt),
    .clr_i  (tx_evt_clr),
    .mask_i (tx_evt_mask),
    .evt_o  (tx_evt),
    .irq_o  (irq)
  );
endmodule

// File: tb/uart_txd_ring_tb_top.sv
module uart_txd_ring_tb_top;
  localparam int AW = 10;
  localparam int TB = 16;

  logic          clk = 1'b0;
  logic          rst_n, enable, tx_ready, tx_evt_clr, tx_evt_mask;
  logic [AW-1:0] tbase;
  logic          mem_rd_en, mem_wr_en, tx_valid, tx_evt, irq;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata, mem_rdata;
  logic [7:0]    tx_data;

  logic [15:0] mem [0:(1<<AW)-1];
  logic [7:0]  exp_q[$];
  string       req_q[$];
  int          n_chk = 0, n_bad = 0;
  int          rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  uart_txd_ring #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tbase(tbase),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_evt_clr(tx_evt_clr), .tx_evt_mask(tx_evt_mask),
    .tx_evt(tx_evt), .irq(irq)
  );

  // RAM model: read data one cycle after the strobe
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic put_desc(input int idx, input logic [15:0] st, input logic [15:0] ln, input logic [31:0] p);
    mem[TB + 4*idx]     <= st;
    mem[TB + 4*idx + 1] <= ln;
    mem[TB + 4*idx + 2] <= p[31:16];
    mem[TB + 4*idx + 3] <= p[15:0];
  endtask

  task automatic put_byte(input int ba, input logic [7:0] v);
    if (ba % 2 == 0) mem[ba/2][15:8] <= v;
    else             mem[ba/2][7:0]  <= v;
  endtask

  task automatic expect_byte(input logic [7:0] v, input string req);
    exp_q.push_back(v);
    req_q.push_back(req);
  endtask

  task automatic wait_done(input int a, input string req);
    int t = 0;
    while (mem[a][15] && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 3000, req, 32'(t), 32'd3000);
  endtask

  // serializer back-pressure driver
  initial begin
    tx_ready = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (rdy_mode)
        0:       tx_ready = lfsr[0] | lfsr[3];
        1:       tx_ready = 1'b0;
        default: tx_ready = 1'b1;
      endcase
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && tx_valid && tx_ready) begin
        if (exp_q.size() == 0) begin
          n_chk++;
          n_bad++;
          $display("FAIL R6 unexpected character act=%h exp=none", tx_data);
        end else begin
          logic [7:0] e;
          string      r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          chk(tx_data == e, r, 32'(tx_data), 32'(e));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R12 watchdog expired act=%0d exp=done", 150000);
    summary();
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; tbase = AW'(TB);
    tx_evt_clr = 1'b0; tx_evt_mask = 1'b0;
    for (int i = 0; i < (1<<AW); i++) mem[i] <= 16'h0000;
    tick(3);
    @(negedge clk);
    // R13 during reset
    chk(!tx_valid && !mem_rd_en && !mem_wr_en, "R13", {tx_valid, mem_rd_en, mem_wr_en}, 0);
    tick(1);
    rst_n = 1'b1;
    tick(2);
    @(negedge clk);
    // R13 after reset
    chk(tx_valid == 0, "R13", 32'(tx_valid), 0);
    chk(tx_evt == 0 && irq == 0, "R13", {tx_evt, irq}, 0);
    chk(!mem_rd_en && !mem_wr_en, "R13", {mem_rd_en, mem_wr_en}, 0);

    // ---- ring with interrupt, preamble-only, odd pointer, wrap ----
    put_desc(0, 16'h9405, 16'd3, 32'h0000_0200);
    put_byte(16'h200, 8'h11); put_byte(16'h201, 8'h22); put_byte(16'h202, 8'h33);
    put_desc(1, 16'h8100, 16'd0, 32'h0);
    put_desc(2, 16'hA100, 16'd2, 32'h0000_0301);
    put_byte(16'h301, 8'h44); put_byte(16'h302, 8'h55);
    put_desc(3, 16'h8000, 16'd1, 32'h0000_0300);
    put_byte(16'h300, 8'hEE);
    expect_byte(8'h11, "R6"); expect_byte(8'h22, "R6"); expect_byte(8'h33, "R6");
    expect_byte(8'hFF, "R7"); expect_byte(8'hFF, "R7");
    expect_byte(8'h44, "R6"); expect_byte(8'h55, "R6");
    tick(1);
    enable = 1'b1;
    wait_done(TB + 8, "R4");
    tick(20);
    enable = 1'b0;
    tick(10);
    @(negedge clk);
    chk(exp_q.size() == 0, "R5", 32'(exp_q.size()), 0);
    chk(mem[TB] == 16'h1405, "R2", 32'(mem[TB]), 32'h1405);
    chk(mem[TB + 4] == 16'h0100, "R4", 32'(mem[TB + 4]), 32'h0100);
    chk(mem[TB + 8] == 16'h2100, "R4", 32'(mem[TB + 8]), 32'h2100);
    chk(mem[TB + 12] == 16'h8000, "R5", 32'(mem[TB + 12]), 32'h8000);
    chk(tx_evt == 1'b1, "R10", 32'(tx_evt), 1);
    chk(irq == 1'b0, "R11", 32'(irq), 0);
    chk(!mem_rd_en && !tx_valid, "R12", {mem_rd_en, tx_valid}, 0);
    tick(1);
    tx_evt_mask = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R11", 32'(irq), 1);
    tick(1);
    tx_evt_clr = 1'b1;
    tick(1);
    tx_evt_clr = 1'b0;
    @(negedge clk);
    chk(tx_evt == 1'b0, "R10", 32'(tx_evt), 0);
    chk(irq == 1'b0, "R11", 32'(irq), 0);

    // ---- zero length, not-ready skip, restart at base ----
    tick(1);
    put_desc(0, 16'h8001, 16'd0, 32'h0);
    put_desc(1, 16'h0002, 16'd2, 32'h0000_0200);
    put_desc(2, 16'hB000, 16'd1, 32'h0000_0208);
    put_byte(16'h208, 8'h66);
    expect_byte(8'h66, "R3");
    tick(1);
    enable = 1'b1;
    wait_done(TB + 8, "R12");
    tick(20);
    enable = 1'b0;
    tick(10);
    @(negedge clk);
    chk(exp_q.size() == 0, "R3", 32'(exp_q.size()), 0);
    chk(mem[TB] == 16'h0001, "R8", 32'(mem[TB]), 32'h0001);
    chk(mem[TB + 4] == 16'h0002, "R3", 32'(mem[TB + 4]), 32'h0002);
    chk(mem[TB + 8] == 16'h3000, "R4", 32'(mem[TB + 8]), 32'h3000);
    chk(tx_evt == 1'b1 && irq == 1'b1, "R10", {tx_evt, irq}, 32'h3);

    // ---- continuous mode, disable while a character waits ----
    tick(1);
    put_desc(0, 16'hA200, 16'd2, 32'h0000_0210);
    put_byte(16'h210, 8'h7A); put_byte(16'h211, 8'h7B);
    for (int k = 0; k < 4; k++) begin
      expect_byte(8'h7A, "R9");
      expect_byte(8'h7B, "R9");
    end
    tick(1);
    enable = 1'b1;
    begin
      int t = 0;
      while (exp_q.size() > 1 && t < 5000) begin
        @(posedge clk);
        #2;
        t++;
      end
      rdy_mode = 1;
      while (!tx_valid && t < 5000) begin
        @(negedge clk);
        t++;
      end
      chk(t < 5000, "R9", 32'(t), 32'd5000);
    end
    tick(1);
    enable = 1'b0;
    tick(4);
    @(negedge clk);
    chk(tx_valid == 1'b1 && tx_data == 8'h7B, "R12", {tx_valid, tx_data}, 32'h17B);
    chk(mem[TB] == 16'hA200, "R9", 32'(mem[TB]), 32'hA200);
    @(posedge clk);
    #2;
    rdy_mode = 2;
    tick(12);
    @(negedge clk);
    chk(exp_q.size() == 0, "R12", 32'(exp_q.size()), 0);
    chk(tx_valid == 1'b0 && mem_rd_en == 1'b0, "R12", {tx_valid, mem_rd_en}, 0);
    chk(mem[TB] == 16'hA200, "R9", 32'(mem[TB]), 32'hA200);
    tick(2);
    summary();
  end
endmodule